// File: doc/BRIEF.md
# Quad-lane serial register target bridge

This block sits in an FPGA and answers a host controller that drives a four-lane serial memory bus in memory-mapped mode. The whole bridge runs on the serial bus clock. Each frame is framed by an active-low select. It decodes the command, the address, the latency gap and the data phase. It turns each frame into single-word register reads and writes on a simple internal bus.

The host may prefetch whole read bursts and may merge nearby writes into one long burst. The register space is therefore sparse: every 32-bit register owns the first word of its own 32-byte slot, and the rest of the slot is padding. The upper half of the slot space holds status words that are visible at two neighbouring slots, so that the host can alternate between the two addresses and force a fresh fetch each time. An optional ready strobe lets the target stall read data for as long as the internal bus needs. Without the strobe, the data phase advances on every clock.

Top module: `qspi_reg_bridge`

## Requirements
- R1: After select falls, a frame carries an 8-bit command and then a 32-bit address, each as 4-bit nibbles with the most significant nibble first. Command bit 7 set means read and clear means write; the other command bits are ignored. A read then has DUMMY idle cycles before data. A write carries data right after the address.
- R2: Address bits [1:0] are ignored, and so are the bits above the slot field. The slot number is address bits [5+SLOT_W-1:5]. Word offset bits [4:2] equal to zero select the register word; any other offset is padding.
- R3: Reading a padding word returns zero and issues no internal read request.
- R4: A read frame keeps supplying sequential words, each most significant nibble first, across slot boundaries, until select rises. The lane drivers are enabled only during the data phase of a read.
- R5: A read never commits a register write.
- R6: For slots whose top slot bit is set, slot bit 0 is cleared on the internal bus, so slots 2k and 2k+1 reach the same register for both reads and writes.
- R7: A write word at slot offset 0 that arrives complete produces a one-cycle write strobe carrying the slot and the data word. Padding words in the burst are dropped. A merged burst commits the first word of every slot it fully covers.
- R8: If select rises in the middle of a word, that word is abandoned without a commit, and decoding restarts at the next frame.
- R9: Each register word is read through one valid/ready request. Valid and the address stay steady until ready, and the data is taken in the ready cycle. At most one request is outstanding.
- R10: With the strobe in use, the strobe stays low while the next word is not ready and high while a valid nibble is on the lanes. The stall may last any number of cycles and loses no data.
- R11: With the strobe disabled, the strobe output stays low and the data phase moves one nibble per clock. A register word that is not ready when its turn comes is sent as zero, and its late answer is discarded.
- R12: In reset, and on the cycle after select is seen high, no request, no write strobe, no lane drive and no strobe are active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial bus clock, also the bridge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low frame select |
| dq_in | input | 4 | Lane inputs from the host |
| dq_out | output | 4 | Lane outputs carrying read data |
| dq_oe | output | 1 | Lane output enable |
| dstb | output | 1 | Read data ready strobe |
| rd_valid | output | 1 | Internal read request valid |
| rd_addr | output | SLOT_W | Internal read register index |
| rd_ready | input | 1 | Internal read accept, data valid |
| rd_data | input | 32 | Internal read data |
| wr_en | output | 1 | One-cycle internal write strobe |
| wr_addr | output | SLOT_W | Internal write register index |
| wr_data | output | 32 | Internal write data |

## Verification
The hardest case to reach is a register answer that arrives after its nibbles have already had to leave without the strobe. This depends on where the word falls in the burst relative to the dummy gap and the prefetch. The bench places a burst so that a padding word comes first. It then sets the responder latency beyond the eight-cycle word window, so the register word misses its turn and its late answer must be discarded rather than shift later words. A second bridge with the strobe enabled gets the same frame, so the stalled and the zero-filled outcomes can be compared. Sweeps over every slot and every word offset, with varied latency, cover the remaining paths: wrap-around, aliasing and padding.

// File: rtl/qspi_reg_bridge.sv
module qspi_reg_bridge #(
  parameter int SLOT_W = 4,
  parameter int DUMMY = 4,
  parameter bit USE_STROBE = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic [3:0]        dq_in,
  output logic [3:0]        dq_out,
  output logic              dq_oe,
  output logic              dstb,
  output logic              rd_valid,
  output logic [SLOT_W-1:0] rd_addr,
  input  logic              rd_ready,
  input  logic [31:0]       rd_data,
  output logic              wr_en,
  output logic [SLOT_W-1:0] wr_addr,
  output logic [31:0]       wr_data
);

  localparam int CNT_W = $clog2(DUMMY > 8 ? DUMMY : 8) + 1;
  localparam int SKIP_W = 4;

  typedef enum logic [1:0] {P_CMD, P_ADDR, P_DUM, P_DATA} ph_t;

  function automatic logic [SLOT_W-1:0] fold(input logic [SLOT_W-1:0] s);
    logic [SLOT_W-1:0] r;
    r = s;
    if (r[SLOT_W-1]) r[0] = 1'b0;
    return r;
  endfunction

  ph_t              ph;
  logic [CNT_W-1:0] cnt;
  logic [27:0]      sh;
  logic [31:0]      pa, cw, bf;
  logic [2:0]       ni;
  logic             rd_mode, cw_ok, bf_ok;
  logic [SKIP_W-1:0] skip;

  wire [31:0] sh_nx    = {sh, dq_in};
  wire        is_reg   = (pa[4:2] == 3'd0);
  wire        fetching = rd_mode && (ph == P_DUM || ph == P_DATA) && !bf_ok;
  wire        fill     = fetching && (!is_reg || rd_ready);
  wire        load     = rd_mode && ((ph == P_DUM && cnt == CNT_W'(DUMMY - 1)) ||
                                     (ph == P_DATA && (!cw_ok || ni == 3'd7)));
  wire        miss     = load && !bf_ok && !USE_STROBE;
  wire        drop     = fill && (skip != '0 || miss);
  wire        wr_word  = !rd_mode && ph == P_DATA && ni == 3'd7;

  assign rd_valid = fetching && is_reg;
  assign rd_addr  = fold(pa[5 +: SLOT_W]);
  assign dq_oe    = rd_mode && ph == P_DATA;
  assign dq_out   = cw[{~ni, 2'b00} +: 4];
  assign dstb     = USE_STROBE && dq_oe && cw_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph <= P_CMD;
      cnt <= '0;
      sh <= '0;
      pa <= '0;
      cw <= '0;
      bf <= '0;
      ni <= '0;
      rd_mode <= 1'b0;
      cw_ok <= 1'b0;
      bf_ok <= 1'b0;
      skip <= '0;
      wr_en <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else if (cs_n) begin
      ph <= P_CMD;
      cnt <= '0;
      ni <= '0;
      rd_mode <= 1'b0;
      cw_ok <= 1'b0;
      bf_ok <= 1'b0;
      skip <= '0;
      wr_en <= 1'b0;
    end else begin
      wr_en <= 1'b0;
      case (ph)
        P_CMD: begin
          sh <= sh_nx[27:0];
          if (cnt == CNT_W'(1)) begin
            rd_mode <= sh_nx[7];
            cnt <= '0;
            ph <= P_ADDR;
          end else cnt <= cnt + 1'b1;
        end
        P_ADDR: begin
          sh <= sh_nx[27:0];
          if (cnt == CNT_W'(7)) begin
            pa <= sh_nx;
            cnt <= '0;
            ph <= rd_mode ? P_DUM : P_DATA;
          end else cnt <= cnt + 1'b1;
        end
        P_DUM: begin
          if (cnt == CNT_W'(DUMMY - 1)) ph <= P_DATA;
          else cnt <= cnt + 1'b1;
        end
        default: begin
          if (!rd_mode) begin
            sh <= sh_nx[27:0];
            ni <= ni + 1'b1;
            if (wr_word) begin
              wr_en <= is_reg;
              wr_addr <= fold(pa[5 +: SLOT_W]);
              wr_data <= sh_nx;
              pa <= pa + 32'd4;
            end
          end else if (cw_ok) begin
            ni <= ni + 1'b1;
          end
        end
      endcase

      if (fill) begin
        pa <= pa + 32'd4;
        if (!drop) begin
          bf <= is_reg ? rd_data : '0;
          bf_ok <= 1'b1;
        end
      end
      skip <= skip + SKIP_W'(miss) - SKIP_W'(drop);

      if (load) begin
        if (bf_ok) begin
          cw <= bf;
          cw_ok <= 1'b1;
          bf_ok <= 1'b0;
        end else if (!USE_STROBE) begin
          cw <= '0;
          cw_ok <= 1'b1;
        end else begin
          cw_ok <= 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/qspi_reg_bridge_chk.sv
module qspi_reg_bridge_chk #(
  parameter int SLOT_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              dq_oe,
  input logic              rd_valid,
  input logic [SLOT_W-1:0] rd_addr,
  input logic              rd_ready,
  input logic              wr_en,
  input logic [SLOT_W-1:0] wr_addr
);

  a_r9_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !cs_n) |=> (rd_valid && $stable(rd_addr)));

  a_r6_alias_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_addr[SLOT_W-1]) |-> !rd_addr[0]);

  a_r6_alias_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr[SLOT_W-1]) |-> !wr_addr[0]);

  a_r5_read_no_write: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !wr_en);

  a_r7_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  a_r12_idle_after_select: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (!rd_valid && !dq_oe && !wr_en));

endmodule

bind qspi_reg_bridge qspi_reg_bridge_chk #(.SLOT_W(SLOT_W)) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .cs_n(cs_n),
  .dq_oe(dq_oe),
  .rd_valid(rd_valid),
  .rd_addr(rd_addr),
  .rd_ready(rd_ready),
  .wr_en(wr_en),
  .wr_addr(wr_addr)
);

// File: tb/qspi_reg_bridge_test.sv
module qspi_reg_bridge_test;
  localparam int SW = 4;
  localparam int DUM = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_s = 1'b1, cs_f = 1'b1;
  logic [3:0] dq_in = '0;

  logic [3:0] dq_out_s, dq_out_f;
  logic dq_oe_s, dq_oe_f, dstb_s, dstb_f;
  logic rd_valid_s, rd_valid_f, rd_ready_s, rd_ready_f;
  logic [SW-1:0] rd_addr_s, rd_addr_f, wr_addr_s, wr_addr_f;
  logic [31:0] rd_data_s, rd_data_f, wr_data_s, wr_data_f;
  logic wr_en_s, wr_en_f;

  logic [31:0] mem [0:15];
  logic [31:0] rw [0:63];
  logic [SW-1:0] cap_a [0:255];
  logic [31:0] cap_d [0:255];
  int ncap = 0, ncap_f = 0;
  int lat_s = 0, lat_f = 0, wt_s = 0, wt_f = 0;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  qspi_reg_bridge #(.SLOT_W(SW), .DUMMY(DUM), .USE_STROBE(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_s), .dq_in(dq_in), .dq_out(dq_out_s),
    .dq_oe(dq_oe_s), .dstb(dstb_s), .rd_valid(rd_valid_s), .rd_addr(rd_addr_s),
    .rd_ready(rd_ready_s), .rd_data(rd_data_s), .wr_en(wr_en_s),
    .wr_addr(wr_addr_s), .wr_data(wr_data_s));

  qspi_reg_bridge #(.SLOT_W(SW), .DUMMY(DUM), .USE_STROBE(1'b0)) uut_fixed (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_f), .dq_in(dq_in), .dq_out(dq_out_f),
    .dq_oe(dq_oe_f), .dstb(dstb_f), .rd_valid(rd_valid_f), .rd_addr(rd_addr_f),
    .rd_ready(rd_ready_f), .rd_data(rd_data_f), .wr_en(wr_en_f),
    .wr_addr(wr_addr_f), .wr_data(wr_data_f));

  assign rd_ready_s = rd_valid_s && (wt_s >= lat_s);
  assign rd_ready_f = rd_valid_f && (wt_f >= lat_f);
  assign rd_data_s = mem[rd_addr_s];
  assign rd_data_f = mem[rd_addr_f];

  always @(posedge clk) begin
    wt_s <= (rd_valid_s && !rd_ready_s) ? wt_s + 1 : 0;
    wt_f <= (rd_valid_f && !rd_ready_f) ? wt_f + 1 : 0;
    if (wr_en_s) begin
      cap_a[ncap % 256] <= wr_addr_s;
      cap_d[ncap % 256] <= wr_data_s;
      ncap <= ncap + 1;
    end
    if (wr_en_f) ncap_f <= ncap_f + 1;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [SW-1:0] bslot(input logic [31:0] a);
    logic [SW-1:0] s;
    s = a[5 +: SW];
    if (s[SW-1]) s[0] = 1'b0;
    return s;
  endfunction

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    return (a[4:2] != 3'd0) ? 32'd0 : mem[bslot(a)];
  endfunction

  function automatic logic [31:0] wword(input logic [31:0] seed, input int k);
    return (seed ^ (32'h1357_9BDF * k)) + k;
  endfunction

  task automatic send_hdr(input logic [7:0] cmd, input logic [31:0] a, input bit fx);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (i == 0) begin
        if (fx) cs_f = 1'b0; else cs_s = 1'b0;
      end
      dq_in = (i < 2) ? cmd[7 - 4*i -: 4] : a[31 - 4*(i-2) -: 4];
    end
  endtask

  task automatic end_frame();
    @(negedge clk);
    cs_s = 1'b1;
    cs_f = 1'b1;
    repeat (2) @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] cmd, input logic [31:0] a, input int nw,
                         input bit fx, output int lowcnt);
    int got, guard;
    logic [3:0] n;
    send_hdr(cmd, a, fx);
    repeat (DUM + 1) @(negedge clk);
    got = 0; guard = 0; lowcnt = 0;
    while (got < nw*8 && guard < 3000) begin
      if (fx || dstb_s) begin
        n = fx ? dq_out_f : dq_out_s;
        rw[got/8] = {rw[got/8][27:0], n};
        got++;
      end else lowcnt++;
      guard++;
      if (got < nw*8) @(negedge clk);
    end
    check(got == nw*8, "R10 burst completes", got, nw*8);
    end_frame();
  endtask

  task automatic do_write(input logic [7:0] cmd, input logic [31:0] a, input int nnib,
                          input logic [31:0] seed);
    logic [31:0] w;
    send_hdr(cmd, a, 1'b0);
    for (int j = 0; j < nnib; j++) begin
      @(negedge clk);
      w = wword(seed, j/8);
      dq_in = w[31 - 4*(j%8) -: 4];
    end
    end_frame();
  endtask

  task automatic check_writes(input logic [31:0] a, input int nnib, input logic [31:0] seed,
                              input int base, input string tag);
    int e;
    logic [31:0] wa;
    e = 0;
    for (int k = 0; k < nnib/8; k++) begin
      wa = {a[31:2], 2'b00} + 32'd4 * k;
      if (wa[4:2] == 3'd0) begin
        check(cap_a[(base+e)%256] == bslot(wa), tag, 32'(cap_a[(base+e)%256]), 32'(bslot(wa)));
        check(cap_d[(base+e)%256] == wword(seed, k), tag, cap_d[(base+e)%256], wword(seed, k));
        e++;
      end
    end
    check(ncap - base == e, tag, ncap - base, e);
  endtask

  task automatic check_burst(input logic [31:0] a, input int nw, input string tag);
    for (int k = 0; k < nw; k++)
      check(rw[k] == exp_rd({a[31:2], 2'b00} + 32'd4 * k), tag, rw[k],
            exp_rd({a[31:2], 2'b00} + 32'd4 * k));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int lc, base;
    logic [31:0] a;
    for (int i = 0; i < 16; i++) mem[i] = (32'h1000_0001 * (i + 1)) ^ 32'h5A5A_0F0F;
    repeat (3) @(negedge clk);
    check(!rd_valid_s && !wr_en_s && !dq_oe_s && !dstb_s, "R12 reset idle strobe",
          {rd_valid_s, wr_en_s, dq_oe_s, dstb_s}, 0);
    check(!rd_valid_f && !wr_en_f && !dq_oe_f && !dstb_f, "R12 reset idle fixed",
          {rd_valid_f, wr_en_f, dq_oe_f, dstb_f}, 0);
    @(negedge clk) rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(!rd_valid_s && !dq_oe_s && !dstb_s, "R12 idle after reset",
          {rd_valid_s, dq_oe_s, dstb_s}, 0);

    base = ncap;
    for (int s = 0; s < 16; s++)
      for (int off = 0; off < 8; off++) begin
        a = 32'(s*32 + off*4) | 32'(s % 4) | ((s % 2) ? 32'h4000_0000 : 32'h0);
        lat_s = ((s + off) % 4) * 3;
        do_read(8'h80, a, 3, 1'b0, lc);
        check_burst(a, 3, "R2 R3 R4 R9 sweep read");
      end
    check(ncap == base, "R5 reads commit nothing", ncap - base, 0);

    lat_s = 0;
    do_read(8'h80, 32'h0, 16, 1'b0, lc);
    check_burst(32'h0, 16, "R4 long burst across slots");

    do_read(8'hFF, 32'h60, 1, 1'b0, lc);
    check(rw[0] == mem[3], "R1 other command bits ignored", rw[0], mem[3]);

    do_read(8'h80, 32'h120, 1, 1'b0, lc);
    check(rw[0] == mem[8], "R6 alias slot 9 reads slot 8", rw[0], mem[8]);
    do_read(8'h80, 32'h100, 1, 1'b0, lc);
    check(rw[0] == mem[8], "R6 alias slot 8", rw[0], mem[8]);

    lat_s = 20;
    do_read(8'h80, 32'h40, 2, 1'b0, lc);
    check(rw[0] == mem[2], "R10 stalled word delivered", rw[0], mem[2]);
    check(rw[1] == 32'd0, "R10 padding after stall", rw[1], 0);
    check(lc >= 15, "R10 strobe held low during stall", lc, 15);

    lat_s = 12;
    do_read(8'h80, 32'h3C, 2, 1'b0, lc);
    check(rw[1] == mem[2], "R10 late word still delivered", rw[1], mem[2]);
    lat_s = 0;

    lat_f = 0;
    for (int s = 0; s < 16; s++) begin
      a = 32'(s*32);
      do_read(8'h80, a, 2, 1'b1, lc);
      check_burst(a, 2, "R11 fixed latency aligned");
      a = 32'(s*32 + 28);
      do_read(8'h80, a, 3, 1'b1, lc);
      check_burst(a, 3, "R11 fixed latency straddle");
    end
    lat_f = 12;
    do_read(8'h80, 32'h3C, 3, 1'b1, lc);
    check(rw[0] == 32'd0, "R11 padding word", rw[0], 0);
    check(rw[1] == 32'd0, "R11 late word sent as zero", rw[1], 0);
    check(rw[2] == 32'd0, "R11 late answer discarded", rw[2], 0);
    lat_f = 0;
    check(!dstb_f, "R11 strobe stays low", dstb_f, 0);
    check(ncap_f == 0, "R5 fixed bridge reads commit nothing", ncap_f, 0);

    base = ncap;
    do_write(8'h02, 32'h60, 16, 32'hCAFE_0001);
    check_writes(32'h60, 16, 32'hCAFE_0001, base, "R7 eight byte write");

    base = ncap;
    do_write(8'h7F, 32'h84, 16, 32'h0BAD_F00D);
    check(ncap == base, "R1 R7 padding write dropped", ncap - base, 0);

    base = ncap;
    do_write(8'h00, 32'h20, 320, 32'h1234_5678);
    check_writes(32'h20, 320, 32'h1234_5678, base, "R7 merged burst");

    base = ncap;
    do_write(8'h00, 32'h5C, 12, 32'h7777_0000);
    check(ncap == base, "R8 partial word abandoned", ncap - base, 0);

    base = ncap;
    do_write(8'h00, 32'h1A0, 8, 32'hA1A1_0001);
    check(ncap - base == 1, "R6 alias write count", ncap - base, 1);
    check(cap_a[base % 256] == 4'd12, "R6 alias write slot", 32'(cap_a[base % 256]), 12);

    for (int s = 0; s < 16; s++) begin
      base = ncap;
      a = 32'(s*32 + 28) | 32'(s % 4);
      do_write(8'h00, a, 24, 32'h5000_0000 + s);
      check_writes(a, 24, 32'h5000_0000 + s, base, "R2 R7 write sweep");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule